// File: doc/BRIEF.md
# Floppy Head Seek Controller

This block positions the read/write head of a floppy drive and manages its spindle motor. A host strobes `start` with a cylinder number, or strobes `recal` to return to cylinder zero. The controller turns the motor on if needed and waits for spin-up. If it does not yet know where the head is, it first drives the head outward until the track-zero sensor reports, plus one extra outward step. It then issues step pulses until its track counter matches the request, waits for the head to settle and pulses `done`.

All long delays count an external one-millisecond tick. The short direction-setup and step-pulse widths come from a counter sized from the system clock frequency. When no seek has been started for longer than the idle limit, the motor is switched off. A later seek then spins it up again and re-homes, since the head position can no longer be trusted. A change on the drive-select input also forces the next seek to re-home.

Top module: `head_seek_ctrl`

## Requirements
- R1: Each step pulse is preceded by at least one microsecond (CLK_HZ/1e6 clocks) of stable `step_dir`. The pulse is high for one microsecond to one microsecond plus one clock, and `step_dir` does not change while it is high.
- R2: `step_dir` is 1 for a step toward track zero and 0 for a step away from it.
- R3: At least STEP_GAP_MS ticks separate the fall of one step pulse from the rise of the next within a seek.
- R4: When not homed, the block steps toward zero until `trk0` is seen high, then issues exactly one more step toward zero. It then sets its track counter to 0 and counts as homed.
- R5: Once homed, the block issues exactly |target − current| steps in the right direction, and `cur_trk` ends equal to the target.
- R6: During a homed seek with the counter not at the target, a high `trk0` forces the counter to 0 before the next step is chosen.
- R7: After the last step, or at once if no step is needed, the block waits SETTLE_MS ticks after the end of the step gap. It then raises `done` for exactly one clock, with `cur_trk` equal to the target.
- R8: A seek accepted while the motor is off raises `motor_en`, clears the homed state and issues no step before SPINUP_MS ticks have passed.
- R9: While idle, `motor_en` falls on the clock after the (IDLE_MS+1)-th tick following the most recent accepted start or recalibrate.
- R10: `recal` clears the homed state and seeks to track 0; if both strobes are high, `recal` wins.
- R11: A change on `drv_sel` clears the homed state, so the next seek re-homes.
- R12: `start` and `recal` are ignored while `busy` is high, and no step is issued while idle.
- R13: After reset `motor_en`, `step_pulse`, `busy` and `done` are low and `cur_trk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-clock pulse every millisecond |
| start | input | 1 | Seek strobe, taken when idle |
| recal | input | 1 | Recalibrate strobe, taken when idle |
| target_trk | input | TRK_W | Requested cylinder |
| drv_sel | input | DSEL_W | Drive-select value; a change forces re-homing |
| trk0 | input | 1 | Track-zero sensor, high at cylinder 0 |
| motor_en | output | 1 | Spindle motor enable |
| step_dir | output | 1 | Step direction, 1 toward zero |
| step_pulse | output | 1 | Step strobe |
| busy | output | 1 | High while a seek is in progress |
| done | output | 1 | One-clock completion pulse |
| cur_trk | output | TRK_W | Current track counter |

## Verification
The embedded assertions check the following on every clock:
- direction is held through each pulse;
- `done` lasts one clock and arrives with the counter at the target;
- no step is issued while idle or with the motor off;
- the latched target stays frozen while busy;
- a track-zero resync leaves the counter at 0 or 1;
- the motor keeper obeys kick and timeout.

Only the bench scenarios can show the following:
- the exact number and direction of steps for homing, the overshoot step and plain seeks;
- the spin-up, step-gap and settle delays measured in ticks;
- the exact tick at which the motor turns off;
- that strobes during a seek and drive-select changes act only on later seeks.

// File: rtl/head_seek_pkg.sv
package head_seek_pkg;

   typedef enum logic [3:0] {
      SK_IDLE,
      SK_SPIN,
      SK_SEEK,
      SK_SETUP,
      SK_PULSE,
      SK_GAP,
      SK_SETTLE,
      SK_DONE
   } hs_state_e;

   function automatic int hs_max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/hs_interval.sv
// Restartable event counter: hit rises once LIMIT events were seen since clr.
module hs_interval #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             evt,
   input  logic [CNT_W-1:0] limit,
   output logic             hit
);
   logic [CNT_W-1:0] cnt_q;

   assign hit = (cnt_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (clr)          cnt_q <= '0;
      else if (evt && !hit)  cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/hs_sync.sv
// Input synchroniser; STAGES = 0 passes the pin straight through.
module hs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_direct
         assign dout = din;
      end else begin : g_flops
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else begin
               sh_q[0] <= din;
               for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
            end
         end
         assign dout = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/hs_motor.sv
// Spindle keeper: on at kick, off once idle past IDLE_MS ticks and not held.
module hs_motor #(
   parameter int IDLE_MS = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   input  logic ms_tick,
   input  logic hold,
   output logic motor_on
);
   localparam int CW = $clog2(IDLE_MS + 2);
   localparam logic [CW-1:0] LIM = CW'(IDLE_MS);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         motor_on <= 1'b0;
         cnt_q    <= '0;
      end else if (kick) begin
         motor_on <= 1'b1;
         cnt_q    <= '0;
      end else begin
         if (motor_on && ms_tick && cnt_q <= LIM) cnt_q <= cnt_q + 1'b1;
         if (motor_on && !hold && cnt_q > LIM)    motor_on <= 1'b0;
      end
   end

   assert_kick_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> motor_on);
   assert_idle_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (motor_on && !hold && !kick && cnt_q > LIM) |=> !motor_on);
endmodule

// File: rtl/head_seek_ctrl.sv
module head_seek_ctrl
   import head_seek_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int TRK_W       = 8,
   parameter int DSEL_W      = 2,
   parameter int SPINUP_MS   = 1000,
   parameter int STEP_GAP_MS = 6,
   parameter int SETTLE_MS   = 50,
   parameter int IDLE_MS     = 5000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ms_tick,
   input  logic              start,
   input  logic              recal,
   input  logic [TRK_W-1:0]  target_trk,
   input  logic [DSEL_W-1:0] drv_sel,
   input  logic              trk0,
   output logic              motor_en,
   output logic              step_dir,
   output logic              step_pulse,
   output logic              busy,
   output logic              done,
   output logic [TRK_W-1:0]  cur_trk
);
   localparam int US_CYC = CLK_HZ / 1_000_000;
   localparam int US_W   = $clog2(US_CYC + 1);
   localparam int MS_MAX = hs_max3(SPINUP_MS, STEP_GAP_MS, SETTLE_MS);
   localparam int MS_W   = $clog2(MS_MAX + 1);

   generate
      if (US_CYC < 1) begin : g_bad_clk
         $error("CLK_HZ must be at least 1 MHz");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0..4");
      end
      if (TRK_W < 2 || DSEL_W < 1) begin : g_bad_width
         $error("TRK_W must be >= 2 and DSEL_W >= 1");
      end
   endgenerate

   hs_state_e         st_q, st_nx;
   logic [TRK_W-1:0]  tgt_q, cur_q, eff_trk;
   logic [DSEL_W-1:0] drv_q;
   logic              homed_q, last_home_q, dir_q;
   logic              trk0_s, us_hit, ms_hit, st_chg, accept, motor_on;
   logic [MS_W-1:0]   ms_limit;

   hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(trk0), .dout(trk0_s));

   hs_interval #(.CNT_W(US_W)) u_us (
      .clk(clk), .rst_n(rst_n), .clr(st_chg), .evt(1'b1),
      .limit(US_W'(US_CYC)), .hit(us_hit));

   hs_interval #(.CNT_W(MS_W)) u_ms (
      .clk(clk), .rst_n(rst_n), .clr(st_chg), .evt(ms_tick),
      .limit(ms_limit), .hit(ms_hit));

   hs_motor #(.IDLE_MS(IDLE_MS)) u_motor (
      .clk(clk), .rst_n(rst_n), .kick(accept), .ms_tick(ms_tick),
      .hold(busy), .motor_on(motor_on));

   assign accept  = (st_q == SK_IDLE) && (start || recal);
   assign eff_trk = trk0_s ? '0 : cur_q;
   assign st_chg  = (st_nx != st_q);

   always_comb begin
      case (st_q)
         SK_SPIN:   ms_limit = MS_W'(SPINUP_MS);
         SK_GAP:    ms_limit = MS_W'(STEP_GAP_MS);
         SK_SETTLE: ms_limit = MS_W'(SETTLE_MS);
         default:   ms_limit = '0;
      endcase
   end

   always_comb begin
      st_nx = st_q;
      case (st_q)
         SK_IDLE:   if (start || recal) st_nx = motor_on ? SK_SEEK : SK_SPIN;
         SK_SPIN:   if (ms_hit) st_nx = SK_SEEK;
         SK_SEEK: begin
            if (!homed_q)                st_nx = SK_SETUP;
            else if (cur_q == tgt_q)     st_nx = SK_SETTLE;
            else if (eff_trk == tgt_q)   st_nx = SK_SETTLE;
            else                         st_nx = SK_SETUP;
         end
         SK_SETUP:  if (us_hit) st_nx = SK_PULSE;
         SK_PULSE:  if (us_hit) st_nx = SK_GAP;
         SK_GAP:    if (ms_hit) st_nx = SK_SEEK;
         SK_SETTLE: if (ms_hit) st_nx = SK_DONE;
         SK_DONE:   st_nx = SK_IDLE;
         default:   st_nx = SK_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= SK_IDLE;
         tgt_q       <= '0;
         cur_q       <= '0;
         drv_q       <= '0;
         homed_q     <= 1'b0;
         last_home_q <= 1'b0;
         dir_q       <= 1'b0;
      end else begin
         st_q <= st_nx;
         case (st_q)
            SK_IDLE: if (accept) tgt_q <= recal ? '0 : target_trk;
            SK_SEEK: begin
               if (!homed_q) begin
                  dir_q       <= 1'b1;
                  last_home_q <= trk0_s;
               end else if (cur_q != tgt_q) begin
                  if (eff_trk < tgt_q) begin
                     dir_q <= 1'b0;
                     cur_q <= eff_trk + 1'b1;
                  end else if (eff_trk > tgt_q) begin
                     dir_q <= 1'b1;
                     cur_q <= eff_trk - 1'b1;
                  end else begin
                     cur_q <= eff_trk;
                  end
               end
            end
            SK_GAP: if (ms_hit && !homed_q && last_home_q) begin
               cur_q       <= '0;
               homed_q     <= 1'b1;
               last_home_q <= 1'b0;
            end
            default: ;
         endcase
         if (accept && (recal || !motor_on)) homed_q <= 1'b0;
         if (drv_sel != drv_q) begin
            homed_q <= 1'b0;
            drv_q   <= drv_sel;
         end
      end
   end

   assign busy       = (st_q != SK_IDLE);
   assign step_pulse = (st_q == SK_PULSE);
   assign done       = (st_q == SK_DONE);
   assign step_dir   = dir_q;
   assign cur_trk    = cur_q;
   assign motor_en   = motor_on;

   assert_dir_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      step_pulse |-> $stable(step_dir));
   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cur_trk == tgt_q));
   assert_step_motor_R8: assert property (@(posedge clk) disable iff (!rst_n)
      step_pulse |-> motor_en);
   assert_resync_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SK_SEEK && homed_q && trk0_s && cur_q != tgt_q) |=> (cur_trk <= 1));
   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !step_pulse);
   assert_target_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(tgt_q));
endmodule

// File: tb/sim_head_seek_ctrl.sv
`timescale 1ns/1ps
module sim_head_seek_ctrl;
   localparam int CLK_HZ = 4_000_000;
   localparam int US     = 4;
   localparam int SPIN   = 1000;
   localparam int GAP    = 6;
   localparam int SETTLE = 50;
   localparam int IDLE   = 5000;

   typedef struct {
      bit    is_done;
      bit    dir;
      int    trk;
      bit    spin;
      string tag;
   } exp_t;

   logic clk = 0, rst_n = 0, ms_tick = 0, start = 0, recal = 0, trk0 = 0;
   logic [7:0] target_trk = 0;
   logic [1:0] drv_sel = 0;
   logic motor_en, step_dir, step_pulse, busy, done;
   logic [7:0] cur_trk;

   int checks = 0, errors = 0;
   exp_t q[$];
   int pos = 3, exp_cur = 0, done_cnt = 0;
   bit force_t0 = 0, start_real = 0, finished = 0;
   int tick_total = 0, tick_since = 0;

   always #2.5 clk = ~clk;

   head_seek_ctrl #(.CLK_HZ(CLK_HZ), .TRK_W(8), .DSEL_W(2), .SPINUP_MS(SPIN),
      .STEP_GAP_MS(GAP), .SETTLE_MS(SETTLE), .IDLE_MS(IDLE), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .start(start), .recal(recal),
      .target_trk(target_trk), .drv_sel(drv_sel), .trk0(trk0),
      .motor_en(motor_en), .step_dir(step_dir), .step_pulse(step_pulse),
      .busy(busy), .done(done), .cur_trk(cur_trk));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   always @(posedge clk) begin
      if (ms_tick) tick_total <= tick_total + 1;
      if (start_real) tick_since <= 0;
      else if (ms_tick) tick_since <= tick_since + 1;
   end

   initial begin
      int tc = 0;
      forever begin
         @(negedge clk);
         tc++;
         ms_tick = (tc % 4 == 0);
      end
   end

   // monitor and drive model
   initial begin
      bit prev_step = 0, prev_motor = 0, have_fall = 0, last_dir = 0, dir_rise = 0;
      int dir_age = 100, hi_cnt = 0, fall_tick = 0;
      exp_t it;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (step_dir !== last_dir) dir_age = 0; else dir_age++;
            last_dir = step_dir;
            if (step_pulse && !prev_step) begin
               hi_cnt = 1; dir_rise = step_dir;
               chk(dir_age >= US, "R1", "dir setup clocks", dir_age, US);
               if (have_fall)
                  chk(tick_total - fall_tick >= GAP, "R3", "step gap ticks", tick_total - fall_tick, GAP);
               if (q.size() == 0) chk(0, "R12", "unexpected step", 1, 0);
               else begin
                  it = q.pop_front();
                  chk(!it.is_done && it.dir == step_dir, it.tag, "step direction", step_dir, it.dir);
                  if (it.spin)
                     chk(tick_since >= SPIN && tick_since <= SPIN + 3, "R8", "spin-up ticks", tick_since, SPIN);
               end
               if (step_dir && pos > 0) pos--;
               else if (!step_dir) pos++;
               force_t0 = 0;
            end else if (step_pulse) begin
               hi_cnt++;
               if (step_dir !== dir_rise) chk(0, "R1", "dir moved in pulse", step_dir, dir_rise);
            end
            if (!step_pulse && prev_step) begin
               chk(hi_cnt >= US && hi_cnt <= US + 1, "R1", "pulse width", hi_cnt, US);
               fall_tick = tick_total; have_fall = 1;
            end
            if (done) begin
               if (q.size() == 0) chk(0, "R7", "unexpected done", 1, 0);
               else begin
                  it = q.pop_front();
                  chk(it.is_done && cur_trk == 8'(it.trk), it.tag, "done track", cur_trk, it.trk);
                  if (have_fall)
                     chk(tick_total - fall_tick >= GAP + SETTLE, "R7", "settle after step", tick_total - fall_tick, GAP + SETTLE);
                  else
                     chk(tick_since >= SETTLE, "R7", "settle without step", tick_since, SETTLE);
               end
               have_fall = 0;
               done_cnt++;
            end
            if (prev_motor && !motor_en)
               chk(tick_since == IDLE + 1, "R9", "motor-off tick", tick_since, IDLE + 1);
            prev_step = step_pulse; prev_motor = motor_en;
         end
         trk0 = force_t0 || (pos == 0);
      end
   end

   task automatic push(input bit d, input bit dir, input int trk, input string tag);
      exp_t e;
      e.is_done = d; e.dir = dir; e.trk = trk; e.spin = 0; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic strobe(input int tgt, input bit rc);
      @(negedge clk);
      start = !rc; recal = rc; target_trk = 8'(tgt); start_real = 1;
      @(negedge clk);
      start = 0; recal = 0; start_real = 0;
   endtask

   task automatic wait_done(input int d0);
      while (done_cnt == d0 && !finished) @(negedge clk);
      repeat (8) @(negedge clk);
      chk(q.size() == 0, "R5", "expected items left", q.size(), 0);
   endtask

   task automatic run_seek(input int tgt, input bit rc, input bit home, input bit spin,
                           input bit poke, input string htag, input string dtag);
      int c, d0;
      if (home) begin
         for (int i = 0; i <= pos; i++) push(0, 1, 0, htag);
         c = 0;
      end else c = exp_cur;
      while (c < tgt) begin push(0, 0, 0, "R5"); c++; end
      while (c > tgt) begin push(0, 1, 0, "R2"); c--; end
      push(1, 0, tgt, dtag);
      if (spin) q[0].spin = 1;
      d0 = done_cnt;
      strobe(tgt, rc);
      if (poke) begin
         repeat (60) @(negedge clk);
         start = 1; target_trk = 9;
         @(negedge clk);
         start = 0; recal = 1;
         @(negedge clk);
         recal = 0;
      end
      wait_done(d0);
      exp_cur = tgt;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R13 reset state
      chk(motor_en == 0, "R13", "motor after reset", motor_en, 0);
      chk(step_pulse == 0 && busy == 0 && done == 0, "R13", "strobes after reset", step_pulse, 0);
      chk(cur_trk == 0, "R13", "track after reset", cur_trk, 0);

      run_seek(5, 0, 1, 1, 0, "R4", "R7");              // spin-up, homing from 3
      run_seek(2, 0, 0, 0, 0, "R2", "R5");              // toward zero
      run_seek(2, 0, 0, 0, 0, "R7", "R7");              // already there
      run_seek(4, 0, 0, 0, 1, "R12", "R12");            // strobes while busy ignored
      repeat (300) @(negedge clk);
      chk(busy == 0 && cur_trk == 4, "R12", "busy strobes had no effect", cur_trk, 4);

      begin : forced_zero                               // R6 resync
         int d0;
         force_t0 = 1;
         repeat (10) @(negedge clk);
         push(0, 0, 0, "R6");
         push(1, 0, 1, "R6");
         d0 = done_cnt;
         strobe(1, 0);
         wait_done(d0);
         exp_cur = 1;
      end

      run_seek(0, 1, 1, 0, 0, "R10", "R10");            // recalibrate from 5
      run_seek(3, 0, 0, 0, 0, "R5", "R5");
      @(negedge clk); drv_sel = 2'd1;
      repeat (5) @(negedge clk);
      run_seek(1, 0, 1, 0, 0, "R11", "R11");            // re-home after select change

      while (motor_en && !finished) @(negedge clk);     // R9 idle timeout
      chk(motor_en == 0, "R9", "motor off after idle", motor_en, 0);
      run_seek(2, 0, 1, 1, 0, "R8", "R8");              // spin-up clears homed

      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule